// File: doc/BRIEF.md
# Translated Page-Walking DMA Channel

This block is a single DMA channel whose logical address space is remapped page by page through a translation table held in memory. Software programs three registers: a control word with enable, direction and interrupt-status bits, a byte count, and a logical start address. The table location and size come in on two shared inputs, `tbl_base` and `tbl_limit`. A device starts a transfer by presenting a one-cycle request with a byte length and a direction.

On acceptance, the channel clears its three status bits and checks the request against the programmed enable and direction. A bad request raises an error flag and a one-cycle pulse on the channel's bit of a shared error-source vector, and nothing else happens. A good request is clamped to the remaining count and then walked through memory one 4 KiB logical page at a time. For each page the channel reads an 8-byte table entry and uses the 32-bit frame word found at its start. It then issues one physical data burst that never crosses the logical page.

When the walk ends, the count register is reduced by the bytes actually moved and the terminal-count flag is set. The walk ends when the request is used up or when the page index runs past the table limit.

Top module: `xlat_dma_chan`

## Requirements
- R1: After reset the control, count and logical-address registers read zero, `busy` is low, `mem_req` is low and `err_set` is all zero.
- R2: The register window decodes `reg_addr[4:3]`: 0 = control (0x00), 1 = count (0x08), 2 = logical address (0x10), 3 (0x18) reads zero and ignores writes. Writes store all 32 bits. Reads are combinational.
- R3: A request is accepted only when `busy` is low. On acceptance control bits 8 (terminal count), 9 (memory error) and 10 (address error) are cleared. A request presented while busy is ignored.
- R4: A request is rejected when control bit 0 (enable) is 0, or when `req_d2m` equals control bit 1 (bit1 = 1 means memory-to-device; `req_d2m` = 1 means device-to-memory). Rejection sets bit 9, pulses `err_set` bit `CHAN_ID` for exactly one cycle, makes no memory access and leaves the count unchanged.
- R5: The transfer length is the smaller of `req_len` and the count register.
- R6: Each data burst stays inside one 4096-byte logical page. Its length is the smaller of the bytes left and 4096 minus the page offset.
- R7: Before each data burst the channel issues a table fetch (`mem_tbl`=1, `mem_we`=0, length 8) at `(tbl_base + page_index*8)` with bit 31 forced to 0. Here page_index = logical address / 4096. The frame is taken from `mem_rdata` at the acknowledge.
- R8: A data burst targets frame + (logical address mod 4096), with `mem_tbl`=0 and `mem_we` equal to `req_d2m`.
- R9: When page_index ≥ `tbl_limit`/8 the walk stops before that page's table fetch, and no further access is made.
- R10: At the end of an accepted request the count is reduced by the bytes moved and bit 8 is set. The logical-address register is not changed.
- R11: `busy` rises on the edge that accepts a valid request and falls on the edge that writes the final count. A transfer of zero bytes finishes with no memory access.
- R12: Once raised, `mem_req` and its address, length and kind are held unchanged until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset in the channel window |
| reg_wdata | input | CW | Register write data |
| reg_rdata | output | CW | Register read data (combinational) |
| tbl_base | input | AW | Translation table base address |
| tbl_limit | input | AW | Translation table size in bytes |
| req_valid | input | 1 | Device transfer request |
| req_len | input | LW | Requested byte length |
| req_d2m | input | 1 | 1 = device-to-memory, 0 = memory-to-device |
| busy | output | 1 | Transfer in progress |
| err_set | output | NUM_CHAN | One-cycle set pulse for the shared error-source register |
| mem_req | output | 1 | Memory access request |
| mem_tbl | output | 1 | 1 = table-entry fetch, 0 = data burst |
| mem_we | output | 1 | Data burst writes memory |
| mem_addr | output | AW | Physical address of the access |
| mem_len | output | PAGE_W+1 | Access length in bytes |
| mem_ack | input | 1 | Access acknowledge |
| mem_rdata | input | AW | Frame word returned with a table-fetch acknowledge |

## Verification
The bench builds the channel with `CHAN_ID` = 2 out of `NUM_CHAN` = 4, so a rejected request must land on a middle bit of `err_set` rather than on bit 0. It keeps the default 32-bit widths and the real 4 KiB page (`PAGE_W` = 12). That lets logical addresses just below a page end produce short-then-full-then-short burst chains over four pages, and table limits that are not multiples of eight exercise the rounding of the limit check. The table base has bit 31 set, so the masking of the entry address can be seen on the memory port.

// File: rtl/xdma_pkg.sv
package xdma_pkg;

    // control-word bit positions (software-visible, decoded by drivers)
    localparam int FLG_EN   = 0;
    localparam int FLG_M2D  = 1;
    localparam int FLG_TC   = 8;
    localparam int FLG_MERR = 9;
    localparam int FLG_AERR = 10;

    // bytes in one translation entry and its shift
    localparam int ENT_BYTES = 8;
    localparam int ENT_SH    = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_ENT  = 2'd2,
        ST_DATA = 2'd3
    } wstate_e;

    // register update requests from the walker
    typedef struct packed {
        logic clr_ints;
        logic set_merr;
        logic set_tc;
        logic dec_en;
    } reg_upd_t;

endpackage

// File: rtl/xdma_regs.sv
module xdma_regs
    import xdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [CW-1:0] wr_data,
    input  logic [1:0]    rd_sel,
    output logic [CW-1:0] rd_data,
    input  reg_upd_t      upd,
    input  logic [CW-1:0] dec_amt,
    output logic [CW-1:0] ctl,
    output logic [CW-1:0] cnt,
    output logic [AW-1:0] laddr
);

    logic [CW-1:0] ctl_nxt;
    logic [CW-1:0] cnt_nxt;

    always_comb begin
        ctl_nxt = ctl;
        if (wr_en && wr_sel == 2'd0) ctl_nxt = wr_data;
        if (upd.clr_ints) ctl_nxt[FLG_AERR:FLG_TC] = '0;
        if (upd.set_merr) ctl_nxt[FLG_MERR] = 1'b1;
        if (upd.set_tc)   ctl_nxt[FLG_TC]   = 1'b1;
    end

    always_comb begin
        cnt_nxt = cnt;
        if (wr_en && wr_sel == 2'd1) cnt_nxt = wr_data;
        if (upd.dec_en) cnt_nxt = cnt - dec_amt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl   <= '0;
            cnt   <= '0;
            laddr <= '0;
        end else begin
            ctl <= ctl_nxt;
            cnt <= cnt_nxt;
            if (wr_en && wr_sel == 2'd2) laddr <= AW'(wr_data);
        end
    end

    always_comb begin
        case (rd_sel)
            2'd0:    rd_data = ctl;
            2'd1:    rd_data = cnt;
            2'd2:    rd_data = CW'(laddr);
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/xdma_walker.sv
module xdma_walker
    import xdma_pkg::*;
#(
    parameter int AW       = 32,
    parameter int CW       = 32,
    parameter int LW       = 16,
    parameter int PAGE_W   = 12,
    parameter int NUM_CHAN = 4,
    parameter int CHAN_ID  = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [LW-1:0]       req_len,
    input  logic                req_d2m,
    input  logic                ctl_en,
    input  logic                ctl_m2d,
    input  logic [CW-1:0]       cnt,
    input  logic [AW-1:0]       laddr,
    input  logic [AW-1:0]       tbl_base,
    input  logic [AW-1:0]       tbl_limit,
    output logic                busy,
    output logic [NUM_CHAN-1:0] err_set,
    output reg_upd_t            upd,
    output logic [CW-1:0]       dec_amt,
    output logic                mem_req,
    output logic                mem_tbl,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [PAGE_W:0]     mem_len,
    input  logic                mem_ack,
    input  logic [AW-1:0]       mem_rdata
);

    localparam int             PIW     = AW - PAGE_W;
    localparam logic [PAGE_W:0] PAGE_SZ = {1'b1, {PAGE_W{1'b0}}};
    localparam logic [AW-1:0]  ADR_MSK = {1'b0, {(AW-1){1'b1}}};

    wstate_e        st;
    logic [AW-1:0]  cur;
    logic [CW-1:0]  remain;
    logic [CW-1:0]  moved;
    logic [AW-1:0]  frame;
    logic           dir_w;

    logic              accept, bad, lim_hit, at_end, finish;
    logic [CW-1:0]     take, len_ext;
    logic [PIW-1:0]    pidx;
    logic [PAGE_W-1:0] off;
    logic [PAGE_W:0]   room, chunk;
    logic [PIW+3:0]    ent_end;
    logic [AW-1:0]     ent_addr;

    assign accept  = (st == ST_IDLE) && req_valid;
    assign bad     = !ctl_en || (req_d2m == ctl_m2d);
    assign len_ext = CW'(req_len);
    assign take    = (len_ext > cnt) ? cnt : len_ext;

    assign pidx    = cur[AW-1:PAGE_W];
    assign off     = cur[PAGE_W-1:0];
    assign ent_end = {(PIW+1)'(pidx) + (PIW+1)'(1), 3'b000};
    assign lim_hit = (AW+4)'(ent_end) > (AW+4)'(tbl_limit);
    assign at_end  = (remain == '0) || lim_hit;
    assign finish  = (st == ST_LOOK) && at_end;

    assign room     = PAGE_SZ - {1'b0, off};
    assign chunk    = (remain < CW'(room)) ? remain[PAGE_W:0] : room;
    assign ent_addr = (tbl_base + AW'({pidx, 3'b000})) & ADR_MSK;

    assign upd.clr_ints = accept;
    assign upd.set_merr = accept && bad;
    assign upd.set_tc   = finish;
    assign upd.dec_en   = finish;
    assign dec_amt      = moved;

    assign busy     = (st != ST_IDLE);
    assign mem_req  = (st == ST_ENT) || (st == ST_DATA);
    assign mem_tbl  = (st == ST_ENT);
    assign mem_we   = (st == ST_DATA) && dir_w;
    assign mem_addr = (st == ST_ENT) ? ent_addr : (frame + AW'(off));
    assign mem_len  = (st == ST_ENT) ? (PAGE_W+1)'(ENT_BYTES) : chunk;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cur     <= '0;
            remain  <= '0;
            moved   <= '0;
            frame   <= '0;
            dir_w   <= 1'b0;
            err_set <= '0;
        end else begin
            err_set <= '0;
            case (st)
                ST_IDLE: begin
                    if (accept) begin
                        if (bad) begin
                            err_set <= NUM_CHAN'(1) << CHAN_ID;
                        end else begin
                            st     <= ST_LOOK;
                            cur    <= laddr;
                            remain <= take;
                            moved  <= '0;
                            dir_w  <= req_d2m;
                        end
                    end
                end
                ST_LOOK: begin
                    st <= at_end ? ST_IDLE : ST_ENT;
                end
                ST_ENT: begin
                    if (mem_ack) begin
                        frame <= mem_rdata;
                        st    <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (mem_ack) begin
                        cur    <= cur + AW'(chunk);
                        remain <= remain - CW'(chunk);
                        moved  <= moved + CW'(chunk);
                        st     <= ST_LOOK;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xlat_dma_chan.sv
module xlat_dma_chan
    import xdma_pkg::*;
#(
    parameter int AW       = 32,
    parameter int CW       = 32,
    parameter int LW       = 16,
    parameter int PAGE_W   = 12,
    parameter int WIN_W    = 5,
    parameter int NUM_CHAN = 4,
    parameter int CHAN_ID  = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [WIN_W-1:0]    reg_addr,
    input  logic [CW-1:0]       reg_wdata,
    output logic [CW-1:0]       reg_rdata,
    input  logic [AW-1:0]       tbl_base,
    input  logic [AW-1:0]       tbl_limit,
    input  logic                req_valid,
    input  logic [LW-1:0]       req_len,
    input  logic                req_d2m,
    output logic                busy,
    output logic [NUM_CHAN-1:0] err_set,
    output logic                mem_req,
    output logic                mem_tbl,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [PAGE_W:0]     mem_len,
    input  logic                mem_ack,
    input  logic [AW-1:0]       mem_rdata
);

    localparam int SEL_LO = 3;

    logic [1:0]    sel;
    reg_upd_t      upd;
    logic [CW-1:0] dec_amt;
    logic [CW-1:0] ctl;
    logic [CW-1:0] cnt;
    logic [AW-1:0] laddr;

    assign sel = reg_addr[SEL_LO+1:SEL_LO];

    xdma_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_we),
        .wr_sel  (sel),
        .wr_data (reg_wdata),
        .rd_sel  (sel),
        .rd_data (reg_rdata),
        .upd     (upd),
        .dec_amt (dec_amt),
        .ctl     (ctl),
        .cnt     (cnt),
        .laddr   (laddr)
    );

    xdma_walker #(
        .AW(AW), .CW(CW), .LW(LW), .PAGE_W(PAGE_W),
        .NUM_CHAN(NUM_CHAN), .CHAN_ID(CHAN_ID)
    ) u_walk (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_len   (req_len),
        .req_d2m   (req_d2m),
        .ctl_en    (ctl[FLG_EN]),
        .ctl_m2d   (ctl[FLG_M2D]),
        .cnt       (cnt),
        .laddr     (laddr),
        .tbl_base  (tbl_base),
        .tbl_limit (tbl_limit),
        .busy      (busy),
        .err_set   (err_set),
        .upd       (upd),
        .dec_amt   (dec_amt),
        .mem_req   (mem_req),
        .mem_tbl   (mem_tbl),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_len   (mem_len),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata)
    );

endmodule

// File: rtl/xdma_chk.sv
module xdma_chk #(
    parameter int AW       = 32,
    parameter int PAGE_W   = 12,
    parameter int NUM_CHAN = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                busy,
    input logic [NUM_CHAN-1:0] err_set,
    input logic                mem_req,
    input logic                mem_tbl,
    input logic [AW-1:0]       mem_addr,
    input logic [PAGE_W:0]     mem_len,
    input logic                mem_ack
);

    localparam logic [PAGE_W:0] PG = {1'b1, {PAGE_W{1'b0}}};

    // R12: request and its attributes hold until acknowledged
    p_hold_req_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_len) && $stable(mem_tbl)));

    // R11: memory traffic only while busy
    p_req_busy_r11: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    // R6: a data burst is non-empty and never longer than one page
    p_burst_page_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_tbl) |-> (mem_len != '0 && mem_len <= PG));

    // R7: table fetch is 8 bytes with the top address bit cleared
    p_tbl_fetch_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_tbl) |-> (!mem_addr[AW-1] && mem_len == (PAGE_W+1)'(8)));

    // R4: an error pulse names one channel and comes with no transfer
    p_err_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        (|err_set) |-> ($onehot0(err_set) && !busy && !mem_req));

endmodule

bind xlat_dma_chan xdma_chk #(.AW(AW), .PAGE_W(PAGE_W), .NUM_CHAN(NUM_CHAN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .err_set  (err_set),
    .mem_req  (mem_req),
    .mem_tbl  (mem_tbl),
    .mem_addr (mem_addr),
    .mem_len  (mem_len),
    .mem_ack  (mem_ack)
);

// File: tb/xlat_dma_chan_bench.sv
module xlat_dma_chan_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 4;
    localparam int CID  = 2;
    localparam logic [31:0] TBASE   = 32'h8001_0000;
    localparam logic [31:0] TBASE_M = 32'h0001_0000;

    typedef struct packed {
        logic [31:0] ctl;
        logic [31:0] cnt;
        logic [31:0] laddr;
        logic [15:0] len;
        logic        d2m;
        logic [31:0] limit;
        logic [31:0] exp_cnt;
        logic [31:0] exp_ctl;
        logic        exp_err;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{32'h401, 32'd100,   32'h10,   16'd64,    1'b1, 32'h100, 32'd36,   32'h101, 1'b0},
        '{32'h001, 32'd20,    32'h20,   16'd64,    1'b1, 32'h100, 32'd0,    32'h101, 1'b0},
        '{32'h003, 32'h1000,  32'hF80,  16'h100,   1'b0, 32'h100, 32'hF00,  32'h103, 1'b0},
        '{32'h001, 32'h3000,  32'h1FF0, 16'h2020,  1'b1, 32'h100, 32'h0FE0, 32'h101, 1'b0},
        '{32'h001, 32'h1000,  32'h1F00, 16'h200,   1'b1, 32'h10,  32'hF00,  32'h101, 1'b0},
        '{32'h100, 32'd50,    32'h0,    16'd10,    1'b1, 32'h100, 32'd50,   32'h200, 1'b1},
        '{32'h001, 32'd50,    32'h0,    16'd10,    1'b0, 32'h100, 32'd50,   32'h201, 1'b1},
        '{32'h003, 32'd50,    32'h0,    16'd10,    1'b1, 32'h100, 32'd50,   32'h203, 1'b1},
        '{32'h001, 32'd0,     32'h40,   16'd10,    1'b1, 32'h100, 32'd0,    32'h101, 1'b0},
        '{32'h001, 32'd40,    32'h40,   16'd10,    1'b1, 32'h7,   32'd40,   32'h101, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] tbl_base = TBASE;
    logic [31:0] tbl_limit = 32'h100;
    logic        req_valid = 1'b0;
    logic [15:0] req_len = '0;
    logic        req_d2m = 1'b0;
    logic        busy;
    logic [NCH-1:0] err_set;
    logic        mem_req, mem_tbl, mem_we;
    logic [31:0] mem_addr;
    logic [12:0] mem_len;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;

    // access log
    int          nlog;
    logic [31:0] lg_addr [16];
    logic [12:0] lg_len  [16];
    logic        lg_tbl  [16];
    logic        lg_we   [16];

    // expected access list
    int          nexp;
    logic [31:0] ex_addr [16];
    logic [12:0] ex_len  [16];
    logic        ex_tbl  [16];
    logic        ex_we   [16];

    xlat_dma_chan #(.NUM_CHAN(NCH), .CHAN_ID(CID)) u_xlat_dma_chan (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tbl_base(tbl_base),
        .tbl_limit(tbl_limit), .req_valid(req_valid), .req_len(req_len),
        .req_d2m(req_d2m), .busy(busy), .err_set(err_set), .mem_req(mem_req),
        .mem_tbl(mem_tbl), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_len(mem_len), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] frame_of(logic [31:0] idx);
        return 32'h0040_0010 + idx * 32'h0000_3000;
    endfunction

    // memory model: acknowledges each request one cycle after seeing it
    always @(negedge clk) begin
        if (mem_req && !mem_ack) begin
            if (nlog < 16) begin
                lg_addr[nlog] = mem_addr;
                lg_len[nlog]  = mem_len;
                lg_tbl[nlog]  = mem_tbl;
                lg_we[nlog]   = mem_we;
            end
            nlog = nlog + 1;
            mem_rdata <= mem_tbl ? frame_of((mem_addr - TBASE_M) >> 3) : 32'h0;
            mem_ack   <= 1'b1;
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // expected accesses derived from R5..R9
    task automatic build_exp(input vec_t v);
        logic [31:0] rem, a, idx, off, ch;
        nexp = 0;
        if (v.exp_err) return;
        rem = (32'(v.len) < v.cnt) ? 32'(v.len) : v.cnt;
        a = v.laddr;
        while (rem != 0 && nexp < 15) begin
            idx = a >> 12;
            if (idx >= (v.limit >> 3)) break;
            ex_addr[nexp] = (TBASE + idx * 8) & 32'h7FFF_FFFF;
            ex_len[nexp]  = 13'd8; ex_tbl[nexp] = 1'b1; ex_we[nexp] = 1'b0;
            nexp = nexp + 1;
            off = a & 32'hFFF;
            ch  = (rem < (32'h1000 - off)) ? rem : (32'h1000 - off);
            ex_addr[nexp] = frame_of(idx) + off;
            ex_len[nexp]  = ch[12:0]; ex_tbl[nexp] = 1'b0; ex_we[nexp] = v.d2m;
            nexp = nexp + 1;
            a = a + ch; rem = rem - ch;
        end
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 2000) begin
            @(negedge clk);
            guard = guard + 1;
        end
    endtask

    task automatic run_vec(input int k, input vec_t v);
        logic [31:0] d;
        logic        errs;
        logic [NCH-1:0] errv;
        wr_reg(5'h00, v.ctl);
        wr_reg(5'h08, v.cnt);
        wr_reg(5'h10, v.laddr);
        tbl_limit = v.limit;
        build_exp(v);
        nlog = 0;
        @(negedge clk);
        req_valid = 1'b1; req_len = v.len; req_d2m = v.d2m;
        @(negedge clk);
        req_valid = 1'b0;
        errv = err_set;
        errs = |err_set;
        // R4: error pulse on this channel's bit only
        check(errs == v.exp_err, $sformatf("R4 vec%0d err pulse", k), 32'(errs), 32'(v.exp_err));
        if (v.exp_err)
            check(errv == NCH'(1 << CID), $sformatf("R4 vec%0d err bit", k), 32'(errv), 32'(1 << CID));
        // R11: busy only for accepted requests
        check(busy == !v.exp_err, $sformatf("R11 vec%0d busy after accept", k), 32'(busy), 32'(!v.exp_err));
        wait_idle();
        @(negedge clk);
        // R5 R6 R7 R8 R9: access list
        check(nlog == nexp, $sformatf("R9 vec%0d access count", k), 32'(nlog), 32'(nexp));
        for (int i = 0; i < nexp && i < nlog; i++) begin
            check(lg_tbl[i] == ex_tbl[i], $sformatf("R7 vec%0d acc%0d kind", k, i), 32'(lg_tbl[i]), 32'(ex_tbl[i]));
            check(lg_addr[i] == ex_addr[i], $sformatf("R8 vec%0d acc%0d addr", k, i), lg_addr[i], ex_addr[i]);
            check(lg_len[i] == ex_len[i], $sformatf("R6 vec%0d acc%0d len", k, i), 32'(lg_len[i]), 32'(ex_len[i]));
            check(lg_we[i] == ex_we[i], $sformatf("R8 vec%0d acc%0d we", k, i), 32'(lg_we[i]), 32'(ex_we[i]));
        end
        rd_reg(5'h00, d);
        check(d == v.exp_ctl, $sformatf("R3 R10 vec%0d ctl flags", k), d, v.exp_ctl);
        rd_reg(5'h08, d);
        check(d == v.exp_cnt, $sformatf("R10 vec%0d count", k), d, v.exp_cnt);
        rd_reg(5'h10, d);
        check(d == v.laddr, $sformatf("R10 vec%0d laddr kept", k), d, v.laddr);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail = n_fail + 1;
        n_chk = n_chk + 1;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        nlog = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        rd_reg(5'h00, d); check(d == 0, "R1 ctl reset", d, 0);
        rd_reg(5'h08, d); check(d == 0, "R1 count reset", d, 0);
        rd_reg(5'h10, d); check(d == 0, "R1 laddr reset", d, 0);
        check(!busy, "R1 busy reset", 32'(busy), 0);
        check(!mem_req, "R1 mem_req reset", 32'(mem_req), 0);
        check(err_set == 0, "R1 err_set reset", 32'(err_set), 0);

        // R2: full-width write and unused slot
        wr_reg(5'h08, 32'hDEAD_BEEF);
        rd_reg(5'h08, d); check(d == 32'hDEAD_BEEF, "R2 count full width", d, 32'hDEAD_BEEF);
        wr_reg(5'h18, 32'h1234_5678);
        rd_reg(5'h18, d); check(d == 0, "R2 slot 0x18 reads zero", d, 0);
        rd_reg(5'h00, d); check(d == 0, "R2 0x18 write leaves ctl", d, 0);

        for (int k = 0; k < NV; k++) run_vec(k, VECS[k]);

        // R3: a second request while busy is ignored
        build_exp(VECS[3]);
        wr_reg(5'h00, 32'h001);
        wr_reg(5'h08, 32'h3000);
        wr_reg(5'h10, 32'h1FF0);
        tbl_limit = 32'h100;
        nlog = 0;
        @(negedge clk);
        req_valid = 1'b1; req_len = 16'h2020; req_d2m = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy, "R11 busy during transfer", 32'(busy), 1);
        @(negedge clk);
        req_valid = 1'b1; req_len = 16'h0010; req_d2m = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        @(negedge clk);
        check(nlog == 8, "R3 refused request adds no access", 32'(nlog), 8);
        rd_reg(5'h08, d); check(d == 32'h0FE0, "R3 refused request keeps count", d, 32'h0FE0);
        check(!busy, "R11 idle after completion", 32'(busy), 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule